// File: doc/BRIEF.md
# Multi-Lane PRBS Word Checker

This block checks a set of parallel receive lanes, each carrying 8-bit words, against a pseudo-random reference that it generates itself. Every lane has its own reference generator. The generator sits idle until that lane's valid input rises. From then on it produces the expected word for each valid cycle. Each lane compares its received word with the expected word. The per-lane results are ANDed into one registered match bit.

A sticky error flag and a saturating error counter record every cycle in which the registered match bit is low while checked data was present. A request input corrupts one bit of one lane for a single cycle. This lets the error path itself be tested.

Each lane follows a two-state machine:
- `LANE_IDLE`: the lane waits for valid.
- `LANE_TRACK`: the lane follows the sequence.

The lane moves through these transitions:
- `IDLE->TRACK` happens on the first valid cycle.
- `TRACK->TRACK` happens on each further valid cycle.
- `TRACK->IDLE` happens when valid drops.
- `IDLE->IDLE` happens while valid stays low.

Top module: `multi_lane_prbs_checker`

## Requirements
- R1: During and right after reset, `match` is 1, `err_flag` is 0 and `err_count` is 0.
- R2: The sequence is PRBS-7 with feedback x^7 + x^6 + 1. The 7-bit state `s` steps to `{s[5:0], s[6]^s[5]}`, and each step emits its new bit. A word is 8 such bits, with the first bit at the MSB. On the first valid cycle of a lane, the expected word is the one generated from state `SEED` (default 7'h7F). Each later valid cycle continues the sequence.
- R3: A lane whose valid is low counts as matching. `match` equals the AND of all lane results, with one cycle of latency.
- R4: When a lane's valid drops, that lane returns to idle. Its next valid cycle is again checked against the word from `SEED`.
- R5: If `match` is 0 and at least one lane was valid in the cycle it reflects, `err_flag` becomes 1 on the next cycle. The flag stays 1 until reset, even if later words match.
- R6: `err_count` (16 bits) increments once per such error cycle. It saturates at 65535 and never wraps.
- R7: A rising edge on `inject_req` inverts bit 0 of lane 0's data for that one cycle only. Holding the request high corrupts no further cycles.
- R8: Asserting `rst_n` low in the middle of operation clears `err_flag` and `err_count` and returns every lane to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_valid | input | LANES | Per-lane data valid from the aligner |
| lane_data | input | 8*LANES | Received words; lane k occupies bits [8k+7:8k] |
| inject_req | input | 1 | Error-insertion request, edge-triggered |
| match | output | 1 | Registered AND of all lane compare results |
| err_flag | output | 1 | Sticky error indicator |
| err_count | output | CNT_W | Saturating error count |

## Verification
The bench targets the following corner cases and what a faulty design would do in each:

- **Staggered lane starts.** Lanes start at different cycles and one lane drops valid and resumes. A generator that is not re-seeded per lane, or that advances while idle, floods the counter with errors.
- **Invalid lane carrying random data.** This would raise false errors if invalid lanes were compared.
- **Held injection request.** Level-triggered injection would count several errors instead of one.
- **Long run of wrong words.** This drives the counter to its ceiling, where a wrapping counter would return to zero.
- **Reset in the middle of operation.** It is applied after the flag has latched, to prove that reset clears it.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int WORD_W = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [6:0]        prbs_st_t;

    typedef enum logic {
        LANE_IDLE,
        LANE_TRACK
    } lane_state_e;

    // one PRBS-7 step, x^7 + x^6 + 1; the new bit enters at the LSB
    function automatic prbs_st_t prbs_step(input prbs_st_t s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    // word emitted from state s, first bit in the MSB
    function automatic word_t prbs_word(input prbs_st_t s);
        prbs_st_t t;
        word_t    w;
        t = s;
        w = '0;
        for (int i = 0; i < WORD_W; i++) begin
            t = prbs_step(t);
            w = {w[WORD_W-2:0], t[0]};
        end
        return w;
    endfunction

    // state after one word's worth of steps
    function automatic prbs_st_t prbs_adv(input prbs_st_t s);
        prbs_st_t t;
        t = s;
        for (int i = 0; i < WORD_W; i++) t = prbs_step(t);
        return t;
    endfunction

endpackage

// File: rtl/prbs_lane_ref.sv
module prbs_lane_ref
    import prbs_chk_pkg::*;
#(
    parameter prbs_st_t SEED = 7'h7F
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid,
    input  word_t data,
    output logic  lane_ok
);

    lane_state_e state_q, state_d;
    prbs_st_t    ref_q, ref_d;
    prbs_st_t    cur;
    word_t       expected;

    // state and reference register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
            ref_q   <= SEED;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
        end
    end

    // next state and compare output
    always_comb begin
        cur      = (state_q == LANE_TRACK) ? ref_q : SEED;
        expected = prbs_word(cur);
        lane_ok  = !valid || (data == expected);
        state_d  = state_q;
        ref_d    = ref_q;
        unique case (state_q)
            LANE_IDLE: begin
                if (valid) begin
                    state_d = LANE_TRACK;
                    ref_d   = prbs_adv(SEED);
                end
            end
            LANE_TRACK: begin
                if (valid) ref_d = prbs_adv(ref_q);
                else       state_d = LANE_IDLE;
            end
        endcase
    end

    // a lane whose valid dropped is idle on the next cycle
    assert_idle_after_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (state_q == LANE_IDLE));

    // an idle lane never reports a mismatch without valid
    assert_invalid_lane_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> lane_ok);

endmodule

// File: rtl/err_inject.sv
module err_inject
    import prbs_chk_pkg::*;
#(
    parameter int LANES    = 17,
    parameter int INJ_LANE = 0,
    parameter int INJ_BIT  = 0,
    localparam int BUS_W   = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [BUS_W-1:0] data_in,
    output logic [BUS_W-1:0] data_out
);

    localparam int FLIP_POS = INJ_LANE * WORD_W + INJ_BIT;

    logic req_q;
    logic pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    always_comb begin
        pulse    = req && !req_q;
        data_out = data_in;
        data_out[FLIP_POS] = data_in[FLIP_POS] ^ pulse;
    end

    // a held request corrupts exactly one cycle
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/err_tally.sv
module err_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             match,
    output logic             err_flag,
    output logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hit;

    always_comb hit = chk_valid && !match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            err_count <= '0;
        end else if (hit) begin
            err_flag <= 1'b1;
            if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
        end
    end

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_flag_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !match) |=> err_flag);

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX) |=> (err_count == CNT_MAX));

    assert_count_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_count >= $past(err_count)));

endmodule

// File: rtl/multi_lane_prbs_checker.sv
module multi_lane_prbs_checker
    import prbs_chk_pkg::*;
#(
    parameter int       LANES    = 17,
    parameter int       CNT_W    = 16,
    parameter prbs_st_t SEED     = 7'h7F,
    parameter int       INJ_LANE = 0,
    parameter int       INJ_BIT  = 0,
    localparam int      BUS_W    = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_valid,
    input  logic [BUS_W-1:0] lane_data,
    input  logic             inject_req,
    output logic             match,
    output logic             err_flag,
    output logic [CNT_W-1:0] err_count
);

    logic [BUS_W-1:0] data_inj;
    logic [LANES-1:0] lane_ok;
    logic             chk_valid_q;

    err_inject #(
        .LANES   (LANES),
        .INJ_LANE(INJ_LANE),
        .INJ_BIT (INJ_BIT)
    ) u_inject (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (inject_req),
        .data_in (lane_data),
        .data_out(data_inj)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        prbs_lane_ref #(.SEED(SEED)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid  (lane_valid[g]),
            .data   (data_inj[g*WORD_W +: WORD_W]),
            .lane_ok(lane_ok[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match       <= 1'b1;
            chk_valid_q <= 1'b0;
        end else begin
            match       <= &lane_ok;
            chk_valid_q <= |lane_valid;
        end
    end

    err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_valid(chk_valid_q),
        .match    (match),
        .err_flag (err_flag),
        .err_count(err_count)
    );

    // with no lane valid, the next match is high
    assert_idle_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|lane_valid) |=> match);

endmodule

// File: tb/multi_lane_prbs_checker_bench.sv
`timescale 1ns/1ps
module multi_lane_prbs_checker_bench;

    localparam int L = 17;
    localparam logic [6:0] SEED = 7'h7F;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [L-1:0]   lane_valid = '0;
    logic [L*8-1:0] lane_data = '0;
    logic           inject_req = 1'b0;
    logic           match, err_flag;
    logic [15:0]    err_count;

    always #2 clk = ~clk;

    multi_lane_prbs_checker u_multi_lane_prbs_checker (
        .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
        .inject_req(inject_req), .match(match), .err_flag(err_flag), .err_count(err_count)
    );

    int    n_checks = 0, n_errors = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural PRBS-7 helpers
    function automatic logic [6:0] b_adv(input logic [6:0] s);
        logic [6:0] t = s;
        repeat (8) t = {t[5:0], t[6] ^ t[5]};
        return t;
    endfunction
    function automatic logic [7:0] b_word(input logic [6:0] s);
        logic [6:0] t = s;
        logic [7:0] w = 0;
        repeat (8) begin
            t = {t[5:0], t[6] ^ t[5]};
            w = {w[6:0], t[0]};
        end
        return w;
    endfunction

    // transmit-side model and stimulus controls
    logic [6:0] tx_st [L];
    bit         want  [L];
    logic [7:0] spoil [L];

    // checker reference model
    bit         m_trk [L];
    logic [6:0] m_st  [L];
    bit         m_match = 1, m_vq = 0, m_flag = 0, m_req_d = 0;
    int         m_cnt = 0;

    task automatic check(input string t, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit ok = 1, any = 0, pulse;
        logic [7:0] d, e;
        if (!rst_n) begin
            for (int l = 0; l < L; l++) m_trk[l] = 0;
            m_match = 1; m_vq = 0; m_flag = 0; m_cnt = 0; m_req_d = 0;
            return;
        end
        pulse = inject_req && !m_req_d;
        if (m_vq && !m_match) begin
            m_flag = 1;
            if (m_cnt < 65535) m_cnt++;
        end
        for (int l = 0; l < L; l++) begin
            d = lane_data[l*8 +: 8];
            if (l == 0 && pulse) d[0] = ~d[0];
            if (lane_valid[l]) begin
                any = 1;
                e = b_word(m_trk[l] ? m_st[l] : SEED);
                if (d != e) ok = 0;
                m_st[l]  = b_adv(m_trk[l] ? m_st[l] : SEED);
                m_trk[l] = 1;
            end else m_trk[l] = 0;
        end
        m_match = ok; m_vq = any; m_req_d = inject_req;
    endtask

    // drive one cycle of stimulus, then model the edge and compare at the negedge
    task automatic cycle();
        for (int l = 0; l < L; l++) begin
            lane_valid[l] = want[l];
            if (want[l]) begin
                lane_data[l*8 +: 8] = b_word(tx_st[l]) ^ spoil[l];
                tx_st[l] = b_adv(tx_st[l]);
            end else begin
                lane_data[l*8 +: 8] = 8'($urandom);
                tx_st[l] = SEED;
            end
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "match",     match,     m_match);
        check(tag, "err_flag",  err_flag,  m_flag);
        check(tag, "err_count", err_count, m_cnt);
    endtask

    task automatic all_want(input bit v);
        for (int l = 0; l < L; l++) begin want[l] = v; spoil[l] = 0; end
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int c0;
        all_want(0);
        for (int l = 0; l < L; l++) tx_st[l] = SEED;
        // R1: reset state
        tag = "R1";
        repeat (3) cycle();
        rst_n = 1'b1;
        repeat (3) cycle();
        // R2: all lanes start together and follow the sequence
        tag = "R2";
        all_want(1);
        repeat (40) cycle();
        check("R2", "no errors on clean sequence", err_count, 0);
        // R3: staggered starts and an invalid lane carrying noise
        tag = "R3";
        all_want(0);
        cycle();
        for (int k = 0; k < L; k++) begin
            if (k != 5) want[k] = 1;
            cycle();
        end
        repeat (20) cycle();
        check("R3", "invalid lane ignored", err_flag, 0);
        // R4: one lane drops valid and restarts from seed
        tag = "R4";
        want[3] = 0; repeat (2) cycle();
        want[3] = 1; repeat (15) cycle();
        check("R4", "restart from seed", err_count, 0);
        // R7: held injection request gives exactly one error
        tag = "R7";
        want[5] = 1;
        repeat (12) cycle();
        c0 = err_count;
        inject_req = 1'b1; repeat (6) cycle();
        inject_req = 1'b0; repeat (4) cycle();
        check("R7", "single injected error", err_count - c0, 1);
        // R5: corrupt one word on lane 9; flag stays after data matches again
        tag = "R5";
        spoil[9] = 8'h10; cycle(); spoil[9] = 0;
        repeat (10) cycle();
        check("R5", "sticky flag", err_flag, 1);
        check("R5", "count after second error", err_count, 2);
        // R8: reset mid-stream clears flag and count
        tag = "R8";
        rst_n = 1'b0; all_want(0);
        repeat (2) cycle();
        check("R8", "flag cleared", err_flag, 0);
        check("R8", "count cleared", err_count, 0);
        rst_n = 1'b1;
        // R6: long run of wrong words saturates the counter
        tag = "R6";
        want[0] = 1; spoil[0] = 8'hFF;
        repeat (65540) cycle();
        check("R6", "saturated count", err_count, 65535);
        spoil[0] = 0; want[0] = 0;
        repeat (3) cycle();
        check("R6", "count held at ceiling", err_count, 65535);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule